// File: doc/BRIEF.md
# Video Line and Frame Timing Generator

The block divides the system clock down to a line rate and counts lines within a frame. Along the way it produces a one-cycle strobe at the start of every line, at the first line of vertical blank and at the start of a new frame. A separate strobe fires every 32 lines for audio-engine updates. A frame start also sets a vsync interrupt request, which stays high until it is acknowledged. The current line number is an output, so a timer elsewhere can count in lines.

Two display standards are supported. The 60 Hz standard has 263 lines with blank starting at line 240. The 50 Hz standard has 313 lines with blank starting at line 256. The clocks-per-line divisor for each standard is derived at elaboration from the `CLK_HZ` parameter. A new value on the standard-select input is taken only at a frame boundary, so a frame is never cut short or stretched part way through.

Top module: `vid_timing_gen`

## Requirements
- R1: The line strobe `line_stb_o` is high for exactly one cycle every D cycles. D is CLK_HZ / (frame rate × lines per frame) in integer division, for the active standard. After reset release the first strobe is in cycle D-1, counting the first rising edge as cycle 1.
- R2: `line_num_o` starts at 0 and increments by one on the edge that ends each line strobe.
- R3: With the 60 Hz standard active (`std_o` = 0), a frame is 263 lines. `vblank_stb_o` pulses for one cycle, in the same cycle that `line_num_o` becomes 240.
- R4: With the 50 Hz standard active (`std_o` = 1), a frame is 313 lines. `vblank_stb_o` pulses for one cycle, in the same cycle that `line_num_o` becomes 256.
- R5: When the last line of a frame ends, `line_num_o` returns to 0. In that same cycle, `frame_stb_o` pulses for one cycle and `vsync_irq_o` goes high.
- R6: `audio_stb_o` pulses for one cycle on every 32nd line strobe, counted from reset. Its count is not restarted by frame boundaries.
- R7: `std_sel_i` (0 = 60 Hz, 1 = 50 Hz) is loaded into `std_o` only on the frame-boundary edge. After reset `std_o` is 0.
- R8: While `rst_ni` is low, the divisor, line and audio counters are cleared. Every strobe and the interrupt request are also low.
- R9: `vsync_irq_o` stays high until a cycle with `irq_ack_i` high clears it. If a frame boundary and an acknowledge fall in the same cycle, the request stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| std_sel_i | input | 1 | Requested standard: 0 = 60 Hz/263 lines, 1 = 50 Hz/313 lines |
| irq_ack_i | input | 1 | Clears the vsync interrupt request |
| line_stb_o | output | 1 | One-cycle pulse at the end of each line period |
| line_num_o | output | 9 | Current line within the frame |
| vblank_stb_o | output | 1 | One-cycle pulse when the blank-start line is entered |
| frame_stb_o | output | 1 | One-cycle pulse when line 0 of a new frame is entered |
| audio_stb_o | output | 1 | One-cycle pulse every 32 lines |
| vsync_irq_o | output | 1 | Sticky vsync interrupt request |
| std_o | output | 1 | Standard currently in effect |

## Verification
The hardest case to reach from the ports is an acknowledge that lands on the exact edge where a frame wraps. Reaching it requires the cycle of the frame boundary to be known exactly. The bench counts cycles from reset release and derives every boundary from the divisor formula. It then drives the acknowledge in the cycle before the wrap of a 50 Hz frame that follows a mid-frame standard change. The same count is used to check that the audio strobe drifts through the frame (it lands on line 25 after the first wrap) rather than restarting with it.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic {STD_60 = 1'b0, STD_50 = 1'b1} vtg_std_e;

  localparam int RATE_60  = 60;
  localparam int RATE_50  = 50;
  localparam int LINES_60 = 263;
  localparam int LINES_50 = 313;
  localparam int VBL_60   = 240;
  localparam int VBL_50   = 256;
  localparam int LINE_W   = $clog2(LINES_50);
endpackage

// File: rtl/vtg_line_div.sv
module vtg_line_div
  import vtg_pkg::*;
#(
  parameter int DIV_60 = 2146,
  parameter int DIV_50 = 2164,
  parameter int CNT_W  = 12
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  vtg_std_e std_i,
  output logic     tick_o
);
  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] div_max;

  always_comb begin
    div_max = (std_i == STD_50) ? CNT_W'(DIV_50 - 1) : CNT_W'(DIV_60 - 1);
    tick_o  = (div_q >= div_max);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/vtg_line_ctr.sv
module vtg_line_ctr
  import vtg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              std_sel_i,
  output logic [LINE_W-1:0] line_o,
  output vtg_std_e          std_o,
  output logic              wrap_o,
  output logic              vblank_stb_o,
  output logic              frame_stb_o
);
  logic [LINE_W-1:0] line_q, line_nxt, last_line, vbl_line;
  vtg_std_e          std_q;
  logic              vbl_q, frame_q;

  always_comb begin
    last_line = (std_q == STD_50) ? LINE_W'(LINES_50 - 1) : LINE_W'(LINES_60 - 1);
    vbl_line  = (std_q == STD_50) ? LINE_W'(VBL_50) : LINE_W'(VBL_60);
    line_nxt  = line_q + 1'b1;
    wrap_o    = tick_i && (line_q == last_line);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      std_q   <= STD_60;
      vbl_q   <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      vbl_q   <= 1'b0;
      frame_q <= 1'b0;
      if (wrap_o) begin
        line_q  <= '0;
        std_q   <= vtg_std_e'(std_sel_i);
        frame_q <= 1'b1;
      end else if (tick_i) begin
        line_q <= line_nxt;
        vbl_q  <= (line_nxt == vbl_line);
      end
    end
  end

  assign line_o       = line_q;
  assign std_o        = std_q;
  assign vblank_stb_o = vbl_q;
  assign frame_stb_o  = frame_q;
endmodule

// File: rtl/vtg_audio_ctr.sv
module vtg_audio_ctr #(
  parameter int AUD_LINES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic stb_o
);
  localparam int AUD_W = (AUD_LINES > 1) ? $clog2(AUD_LINES) : 1;

  logic [AUD_W-1:0] aud_q;
  logic             stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aud_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (tick_i) begin
        if (aud_q == AUD_W'(AUD_LINES - 1)) begin
          aud_q <= '0;
          stb_q <= 1'b1;
        end else begin
          aud_q <= aud_q + 1'b1;
        end
      end
    end
  end

  assign stb_o = stb_q;
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter int CLK_HZ    = 33868800,
  parameter int AUD_LINES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              std_sel_i,
  input  logic              irq_ack_i,
  output logic              line_stb_o,
  output logic [LINE_W-1:0] line_num_o,
  output logic              vblank_stb_o,
  output logic              frame_stb_o,
  output logic              audio_stb_o,
  output logic              vsync_irq_o,
  output logic              std_o
);
  localparam int DIV_60  = CLK_HZ / (RATE_60 * LINES_60);
  localparam int DIV_50  = CLK_HZ / (RATE_50 * LINES_50);
  localparam int DIV_MAX = (DIV_60 > DIV_50) ? DIV_60 : DIV_50;
  localparam int CNT_W   = $clog2(DIV_MAX + 1);

  vtg_std_e std_act;
  logic     tick, wrap, irq_q;

  vtg_line_div #(.DIV_60(DIV_60), .DIV_50(DIV_50), .CNT_W(CNT_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .std_i  (std_act),
    .tick_o (tick)
  );

  vtg_line_ctr i_line (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .std_sel_i    (std_sel_i),
    .line_o       (line_num_o),
    .std_o        (std_act),
    .wrap_o       (wrap),
    .vblank_stb_o (vblank_stb_o),
    .frame_stb_o  (frame_stb_o)
  );

  vtg_audio_ctr #(.AUD_LINES(AUD_LINES)) i_aud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .stb_o  (audio_stb_o)
  );

  // set beats acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (wrap)      irq_q <= 1'b1;
    else if (irq_ack_i) irq_q <= 1'b0;
  end

  assign line_stb_o  = tick;
  assign vsync_irq_o = irq_q;
  assign std_o       = std_act;
endmodule

// File: rtl/vtg_chk.sv
module vtg_chk
  import vtg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_ack_i,
  input logic              line_stb_o,
  input logic [LINE_W-1:0] line_num_o,
  input logic              vblank_stb_o,
  input logic              frame_stb_o,
  input logic              audio_stb_o,
  input logic              vsync_irq_o,
  input logic              std_o
);
  // R1
  line_stb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_stb_o |=> !line_stb_o);
  // R2
  line_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_num_o) |-> $past(line_stb_o));
  // R3
  line_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_num_o <= (std_o ? LINE_W'(LINES_50 - 1) : LINE_W'(LINES_60 - 1)));
  // R4
  vblank_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_stb_o |-> line_num_o == (std_o ? LINE_W'(VBL_50) : LINE_W'(VBL_60)));
  // R5
  frame_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_o |-> (vsync_irq_o && line_num_o == '0));
  // R6
  audio_on_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    audio_stb_o |-> $past(line_stb_o));
  // R7
  std_at_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(std_o) |-> frame_stb_o);
  // R9
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vsync_irq_o) |-> $past(irq_ack_i));
endmodule

bind vid_timing_gen vtg_chk i_vtg_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_ack_i    (irq_ack_i),
  .line_stb_o   (line_stb_o),
  .line_num_o   (line_num_o),
  .vblank_stb_o (vblank_stb_o),
  .frame_stb_o  (frame_stb_o),
  .audio_stb_o  (audio_stb_o),
  .vsync_irq_o  (vsync_irq_o),
  .std_o        (std_o)
);

// File: tb/test_vid_timing_gen.sv
module test_vid_timing_gen;
  localparam int CLK_HZ = 78900;
  localparam int D60 = CLK_HZ / (60 * 263);
  localparam int D50 = CLK_HZ / (50 * 313);

  logic clk = 1'b0, rst_n = 1'b0, std_sel = 1'b0, ack = 1'b0;
  logic line_stb, vbl_stb, frm_stb, aud_stb, irq, std;
  logic [8:0] line_num;
  int cyc = 0, errors = 0, checks = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  vid_timing_gen #(.CLK_HZ(CLK_HZ)) i_vid_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .std_sel_i(std_sel), .irq_ack_i(ack),
    .line_stb_o(line_stb), .line_num_o(line_num), .vblank_stb_o(vbl_stb),
    .frame_stb_o(frm_stb), .audio_stb_o(aud_stb), .vsync_irq_o(irq), .std_o(std));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic pick(input int which);
    case (which)
      0: return line_stb;
      1: return vbl_stb;
      2: return frm_stb;
      default: return aud_stb;
    endcase
  endfunction

  task automatic wait_sig(input int which);
    do @(negedge clk); while (!pick(which));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(line_num == 0, "R8 line", line_num, 0);
    chk({line_stb, vbl_stb, frm_stb, aud_stb, irq} == 5'b0, "R8 strobes", {line_stb, vbl_stb, frm_stb, aud_stb, irq}, 0);
    chk(std == 1'b0, "R7 reset std", std, 0);
  endtask

  task automatic t_line();
    wait_sig(0);
    chk(cyc == D60 - 1, "R1 first strobe", cyc, D60 - 1);
    chk(line_num == 0, "R2 line", line_num, 0);
    wait_sig(0);
    chk(cyc == 2 * D60 - 1, "R1 period", cyc, 2 * D60 - 1);
    chk(line_num == 1, "R2 line", line_num, 1);
    @(negedge clk);
    chk(line_stb == 1'b0, "R1 width", line_stb, 0);
    chk(line_num == 2, "R2 step", line_num, 2);
  endtask

  task automatic t_vblank60();
    wait_sig(1);
    chk(cyc == 240 * D60, "R3 vblank cycle", cyc, 240 * D60);
    chk(line_num == 240, "R3 vblank line", line_num, 240);
    @(negedge clk);
    chk(vbl_stb == 1'b0, "R3 vblank width", vbl_stb, 0);
  endtask

  task automatic t_frame60();
    wait_sig(2);
    chk(cyc == 263 * D60, "R3 frame length", cyc, 263 * D60);
    chk(line_num == 0, "R5 wrap", line_num, 0);
    chk(irq == 1'b1, "R5 irq", irq, 1);
    @(negedge clk);
    chk(frm_stb == 1'b0, "R5 width", frm_stb, 0);
    chk(irq == 1'b1, "R9 sticky", irq, 1);
  endtask

  task automatic t_audio();
    wait_sig(3);
    chk(cyc == 288 * D60, "R6 audio cycle", cyc, 288 * D60);
    chk(line_num == 25, "R6 no frame restart", line_num, 25);
    wait_sig(3);
    chk(cyc == 320 * D60, "R6 interval", cyc, 320 * D60);
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic t_ack();
    @(negedge clk);
    pulse_ack();
    chk(irq == 1'b0, "R9 ack clears", irq, 0);
  endtask

  task automatic t_std_switch();
    int f0, f1;
    std_sel = 1'b1;
    repeat (20) @(negedge clk);
    chk(std == 1'b0, "R7 held mid-frame", std, 0);
    wait_sig(2);
    f0 = 526 * D60;
    chk(cyc == f0, "R7 boundary cycle", cyc, f0);
    chk(std == 1'b1, "R7 switched", std, 1);
    pulse_ack();
    wait_sig(1);
    chk(cyc == f0 + 256 * D50, "R4 vblank cycle", cyc, f0 + 256 * D50);
    chk(line_num == 256, "R4 vblank line", line_num, 256);
    f1 = f0 + 313 * D50;
    while (cyc != f1 - 1) @(negedge clk);
    pulse_ack();
    chk(frm_stb == 1'b1, "R4 frame length", frm_stb, 1);
    chk(irq == 1'b1, "R9 set beats ack", irq, 1);
    std_sel = 1'b0;
    wait_sig(2);
    chk(cyc == f1 + 313 * D50, "R7 kept 50 Hz frame", cyc, f1 + 313 * D50);
    chk(std == 1'b0, "R7 back to 60", std, 0);
    f0 = f1 + 313 * D50;
    wait_sig(2);
    chk(cyc == f0 + 263 * D60, "R3 60 Hz frame again", cyc, f0 + 263 * D60);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=finish", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_line();
    t_vblank60();
    t_frame60();
    t_audio();
    t_ack();
    t_std_switch();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule